// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets a host microcontroller write and read a small bank of 8-bit configuration registers over a four-wire serial link. The host lowers an active-low select, clocks bytes in on SDI with SCK, and receives bytes on SDO. While select stays low, the incoming bytes take turns as address and data. The first byte is an address byte. The next byte is its data byte, then another address byte follows, and so on. A whole set of registers can therefore be written or read in one select window without toggling select between accesses. Whenever select is raised, the byte phase returns to address.

An address byte names one register and says whether the access is a read or a write. For a write, the following data byte is stored in that register. For a read, the register contents are shifted out on SDO during the following byte, and whatever the host sends on SDI at that time is ignored. Every register also drives a parallel output bus that feeds the rest of the chip.

SCK, SDI and select are sampled by the block's system clock. The link is therefore meant to run well below that clock's rate.

Top module: `spi_cfg_slave`

## Requirements
- R1: After synchronous reset every register reads 0x00, the parallel output bus is all zero and SDO is low.
- R2: An address byte uses bit 7 as the access type (1 = read, 0 = write) and bits 6:0 as the register index. SDO stays low during address bytes and during write data bytes.
- R3: A write stores its data byte in the indexed register once the eighth data bit has been received. While select stays low, bytes alternate address/data, so several writes fit in one select window.
- R4: A read data byte is shifted out on SDO MSB first. SDO changes after SCK falls and is stable at each SCK rise. Whatever arrives on SDI during a read data byte (zeros or ones) changes no register.
- R5: Several reads can follow one another in one select window, each made of an address byte followed by a data byte.
- R6: Raising select between the two bytes of an access cancels that access, and the next byte received is taken as an address.
- R7: A byte that is cut short by select rising is discarded, and the bit count starts again at the next select window.
- R8: An index at or above NUM_REGS reads as 0x00 and writes to it are ignored.
- R9: SDO is driven low whenever select is high.
- R10: The parallel output carries register i on bits [8*i+7 : 8*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host; idles low, SDI is sampled on its rising edge |
| sdi | input | 1 | Serial data from the host, MSB first |
| sel_n | input | 1 | Active-low configuration select |
| sdo | output | 1 | Serial read data to the host |
| cfg_o | output | NUM_REGS*8 | Parallel contents of all registers |

## Verification
SCK, SDI and select each pass through SYNC_STAGES flops and then through one edge-detect flop. SDO therefore settles about four system clocks after an SCK fall, and a register write shows on cfg_o about four clocks after the eighth rising edge of the data byte. The bench holds each SCK level for six system clocks. It reads SDO at the instant it raises SCK, just as a host does, and compares every received byte with the byte predicted by a behavioural model of the address/data alternation. The register bus is compared with the model eight clocks after select rises, when every pending write has had time to land.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } byte_phase_e;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= rst_val;
          else     pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= rst_val;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rise,
  input  logic          sdi,
  output logic          byte_done,
  output logic [DW-1:0] byte_val,
  output logic          at_boundary
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (rise) begin
      shreg <= {shreg[DW-3:0], sdi};
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign byte_done   = rise && (cnt == LAST);
  assign byte_val    = {shreg, sdi};
  assign at_boundary = (cnt == '0);

  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (cnt == '0)); // R7

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DW-2:0]          wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [DW-2:0]          rd_idx,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  localparam int IW = DW - 1;
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IW:0] LIMIT = (IW+1)'(NUM_REGS);

  logic [DW-1:0] mem [NUM_REGS];
  logic          rd_in_range;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                                mem[g] <= '0;
        else if (wr_en && (wr_idx == IW'(g)))   mem[g] <= wr_data;
      end
      assign regs_flat[g*DW +: DW] = mem[g];
    end
  endgenerate

  assign rd_in_range = ({1'b0, rd_idx} < LIMIT);
  assign rd_data     = rd_in_range ? mem[rd_idx[AW-1:0]] : '0;

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_idx} < LIMIT)); // R8

  AST_ONLY_WRITE_CHANGES: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(regs_flat)); // R3

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sck,
  input  logic                   sdi,
  input  logic                   sel_n,
  output logic                   sdo,
  output logic [NUM_REGS*DW-1:0] cfg_o
);

  localparam int IW = DW - 1;
  localparam logic [IW:0] LIMIT = (IW+1)'(NUM_REGS);

  logic [2:0]    sync_q;
  logic          sck_s, sdi_s, sel_n_s, sck_d;
  logic          rise, fall;
  logic          byte_done, at_boundary;
  logic [DW-1:0] byte_val;
  byte_phase_e   phase;
  logic          rd_q;
  logic [IW-1:0] idx_q;
  logic          wr_en;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] tx;

  spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (3'b100),
    .d       ({sel_n, sck, sdi}),
    .q       (sync_q)
  );

  assign {sel_n_s, sck_s, sdi_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign rise = !sel_n_s &&  sck_s && !sck_d;
  assign fall = !sel_n_s && !sck_s &&  sck_d;

  spi_cfg_shifter #(.DW(DW)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .clear       (sel_n_s),
    .rise        (rise),
    .sdi         (sdi_s),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .at_boundary (at_boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ADDR;
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else if (sel_n_s) begin
      phase <= PH_ADDR;
    end else if (byte_done) begin
      if (phase == PH_ADDR) begin
        rd_q  <= byte_val[DW-1];
        idx_q <= byte_val[IW-1:0];
        phase <= PH_DATA;
      end else begin
        phase <= PH_ADDR;
      end
    end
  end

  assign wr_en = byte_done && (phase == PH_DATA) && !rd_q &&
                 ({1'b0, idx_q} < LIMIT);

  spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (idx_q),
    .wr_data   (byte_val),
    .rd_idx    (idx_q),
    .rd_data   (rd_data),
    .regs_flat (cfg_o)
  );

  always_ff @(posedge clk) begin
    if (rst || sel_n_s) begin
      tx <= '0;
    end else if (fall) begin
      if (at_boundary) tx <= ((phase == PH_DATA) && rd_q) ? rd_data : '0;
      else             tx <= {tx[DW-2:0], 1'b0};
    end
  end

  assign sdo = tx[DW-1];

  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n_s) |-> !sdo); // R9

  AST_DESELECT_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n_s) |-> (phase == PH_ADDR)); // R6

  AST_READ_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (byte_done && (phase == PH_DATA) && rd_q) |=> $stable(cfg_o)); // R4

  AST_ADDR_BYTE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) && $past(phase == PH_ADDR) && !$past(fall) |-> $stable(tx)); // R2

endmodule

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;

  localparam int NUM_REGS = 16;
  localparam int DW       = 8;
  localparam int HALF     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sel_n = 1'b1;
  logic sdo;
  logic [NUM_REGS*DW-1:0] cfg_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference model
  logic [7:0] m_regs [NUM_REGS];
  bit         m_data_phase;
  bit         m_rd;
  int         m_idx;

  always #4 clk = ~clk;

  spi_cfg_slave #(.NUM_REGS(NUM_REGS), .DW(DW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .sel_n(sel_n),
    .sdo(sdo), .cfg_o(cfg_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected SDO byte for the next byte, then advance the model
  task automatic model_byte(input logic [7:0] b, output logic [7:0] exp_rx);
    if (m_data_phase && m_rd) exp_rx = (m_idx < NUM_REGS) ? m_regs[m_idx] : 8'h00;
    else                      exp_rx = 8'h00;
    if (!m_data_phase) begin
      m_rd  = b[7];
      m_idx = int'(b[6:0]);
      m_data_phase = 1'b1;
    end else begin
      if (!m_rd && m_idx < NUM_REGS) m_regs[m_idx] = b;
      m_data_phase = 1'b0;
    end
  endtask

  task automatic start_frame();
    sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_frame();
    wait_clk(HALF);
    sel_n = 1'b1;
    m_data_phase = 1'b0;
    wait_clk(8);
  endtask

  task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      wait_clk(HALF);
      sck = 1'b1;
      rx[i] = sdo;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, input string req);
    logic [7:0] rx, exp_rx;
    model_byte(b, exp_rx);
    shift_bits(b, 8, rx);
    check(rx === exp_rx, req, rx, exp_rx);
  endtask

  task automatic check_regs(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cfg_o[i*8 +: 8] !== m_regs[i]) begin
        if (ok) bad = i;
        ok = 1'b0;
      end
    end
    check(ok, req, int'(cfg_o[bad*8 +: 8]), int'(m_regs[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < NUM_REGS; i++) m_regs[i] = 8'h00;
    m_data_phase = 1'b0; m_rd = 1'b0; m_idx = 0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R1 reset state, R10 bus layout
    check_regs("R1 reset registers");
    check(sdo === 1'b0, "R1 sdo after reset", sdo, 0);

    // R3 single write; R10 bus slot
    start_frame(); xfer(8'h03, "R2 addr byte sdo low"); xfer(8'hA5, "R2 write data sdo low"); end_frame();
    check(cfg_o[3*8 +: 8] === 8'hA5, "R10 slot of register 3", cfg_o[3*8 +: 8], 8'hA5);
    check_regs("R3 single write");

    // R3 burst of writes without deselect
    start_frame();
    xfer(8'h00, "R3 burst"); xfer(8'h11, "R3 burst");
    xfer(8'h01, "R3 burst"); xfer(8'h22, "R3 burst");
    xfer(8'h0F, "R3 burst"); xfer(8'hF0, "R3 burst");
    end_frame();
    check_regs("R3 burst write");

    // R4 read with zeros in data phase
    start_frame(); xfer(8'h83, "R4 addr"); xfer(8'h00, "R4 read reg3 zeros in"); end_frame();
    check_regs("R4 zeros in read phase");
    // R4 read with ones in data phase
    start_frame(); xfer(8'h8F, "R4 addr"); xfer(8'hFF, "R4 read regF ones in"); end_frame();
    check_regs("R4 ones in read phase");

    // R5 back-to-back reads, then write and read back in same window
    start_frame();
    xfer(8'h80, "R5 addr"); xfer(8'h00, "R5 read reg0");
    xfer(8'h81, "R5 addr"); xfer(8'h5A, "R5 read reg1");
    xfer(8'h09, "R5 addr"); xfer(8'h69, "R5 write reg9");
    xfer(8'h89, "R5 addr"); xfer(8'h00, "R5 read reg9 after write");
    end_frame();
    check_regs("R5 reads left registers intact");

    // R6 deselect after address byte
    start_frame(); xfer(8'h05, "R6 addr reg5"); end_frame();
    start_frame(); xfer(8'h07, "R6 new addr"); xfer(8'h3C, "R6 data"); end_frame();
    check(cfg_o[5*8 +: 8] === 8'h00, "R6 reg5 untouched", cfg_o[5*8 +: 8], 8'h00);
    check_regs("R6 next byte was address");

    // R7 partial address byte then full write
    start_frame(); shift_bits(8'hFF, 5, rx); sel_n = 1'b1; wait_clk(8);
    start_frame(); xfer(8'h04, "R7 addr after partial"); xfer(8'h81, "R7 data"); end_frame();
    check_regs("R7 partial address dropped");
    // R7 partial data byte
    start_frame(); xfer(8'h06, "R7 addr"); shift_bits(8'hEE, 4, rx); sel_n = 1'b1;
    m_data_phase = 1'b0; wait_clk(8);
    check(cfg_o[6*8 +: 8] === 8'h00, "R7 partial data not stored", cfg_o[6*8 +: 8], 8'h00);

    // R8 out of range write and read
    start_frame(); xfer(8'h50, "R8 addr"); xfer(8'hDE, "R8 write oor"); end_frame();
    check_regs("R8 oor write ignored");
    start_frame(); xfer(8'hFF, "R8 addr"); xfer(8'h00, "R8 read oor zero"); end_frame();

    // R9 SDO low while deselected after a read of ones
    start_frame(); xfer(8'h8F, "R9 addr"); shift_bits(8'h00, 1, rx);
    check(rx[7] === 1'b1, "R9 first read bit", rx[7], 1);
    sel_n = 1'b1; m_data_phase = 1'b0; wait_clk(6);
    check(sdo === 1'b0, "R9 sdo low deselected", sdo, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule